// File: doc/BRIEF.md
# Register-Controlled Serial Flash Master

This block is a single-target serial peripheral interface master driven through a small memory-mapped register file. Software places a word of up to 32 bits in a one-word transmit holding register, programs the bit count, clock polarity, clock phase and clock divider in the control register, and sets the start bit. The block then shifts the requested number of bits out on MOSI, most significant first, while capturing the same number of bits from MISO. The captured word is right-aligned into a one-word receive holding register.

The status register reports activity, completion and the fill state of both holding registers. Its error and completion flags are sticky and cleared by writing 1. Chip select is active low. It can be left to the hardware, which asserts it only around a transfer, or placed under software control so that one selection spans several words.

The register port takes one request per cycle with no back-pressure: `bus_ready` is always high, and a read returns its data with `rd_valid` on the cycle after the request. Byte offsets are used: control 0x00, status 0x04, transmit 0x10, receive 0x20. Every other offset reads zero and ignores writes.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x0280_0000 (both holding registers empty), chip select is high and SCLK is low.
- R2: Writing control bit 30 while idle starts a transfer of (control[4:0] + 1) bits, taken from the low end of the transmit word and sent most significant first; bit 30 reads 1 until the transfer ends.
- R3: The received bits fill the receive word from bit N-1 down to bit 0 with the upper bits zero, and the word is stored only when control bit 14 is 1; with control bit 15 at 0, MOSI sends zeros.
- R4: A nonzero control[27:26] makes SCLK idle high; a nonzero control[19:18] moves MOSI sampling from the leading to the trailing SCLK edge.
- R5: Each SCLK half-period lasts control[25:22] + 1 system clocks.
- R6: Status bit 31 (busy) is high from the start write until the received word is stored, and status bit 30 (done) is set when busy falls.
- R7: Status bits 30, 27 and 26 are cleared by writing 1 and left unchanged by writing 0.
- R8: Writing the transmit register while it is full sets status bit 26 and drops the data; reading the receive register while it is empty sets status bit 27 and returns 0.
- R9: With control bit 12 at 1, chip select is low when control bit 13 is 1 and high when it is 0; with bit 12 at 0, chip select is low only while busy.
- R10: Status bits 25/24 flag receive empty/full and 23/22 transmit empty/full; writing 1 to status bit 29 empties the receive register and bit 28 the transmit register, and both read 0.
- R11: Every request is accepted, a read returns data with `rd_valid` one cycle later, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request present |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always high) |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach from the ports is the sample edge in each of the four polarity/phase combinations. The data is only right if MOSI is stable on that edge and if the final edge still falls inside the chip-select window. The bench wires MISO to the inverse of MOSI and watches SCLK and chip select with a monitor that knows the mode. For each vector it rebuilds both the bit stream seen on the wire and the half-period, so a wrong edge choice, a missing last bit or a wrong divider shows up as a mismatch against a word computed from the vector alone.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 6;
  localparam int LEN_W  = $clog2(REG_W);
  localparam int HALF_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_TXW  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_RXW  = 6'h20;

  // control bit positions
  localparam int C_START   = 30;
  localparam int C_POL_HI  = 27;
  localparam int C_POL_LO  = 26;
  localparam int C_HALF_HI = 25;
  localparam int C_HALF_LO = 22;
  localparam int C_PHA_HI  = 19;
  localparam int C_PHA_LO  = 18;
  localparam int C_TXEN    = 15;
  localparam int C_RXEN    = 14;
  localparam int C_CSVAL   = 13;
  localparam int C_CSSW    = 12;

  // status bit positions
  localparam int S_BUSY  = 31;
  localparam int S_DONE  = 30;
  localparam int S_RXFL  = 29;
  localparam int S_TXFL  = 28;
  localparam int S_UNR   = 27;
  localparam int S_OVF   = 26;
  localparam int S_RXE   = 25;
  localparam int S_RXF   = 24;
  localparam int S_TXE   = 23;
  localparam int S_TXF   = 22;

  typedef struct packed {
    logic [1:0]        pol;
    logic [HALF_W-1:0] half;
    logic [1:0]        pha;
    logic              tx_en;
    logic              rx_en;
    logic              cs_val;
    logic              cs_sw;
    logic [LEN_W-1:0]  len;
  } ctrl_t;
endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (cnt_q == half) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == half);
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int DW = 32,
  parameter int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic          pha,
  input  logic [DW-1:0] tx_word,
  input  logic          miso,
  input  logic          tick,
  output logic          running,
  output logic          sclk_raw,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam logic [LW-1:0] TOP_IDX = LW'(DW - 1);

  logic [DW-1:0] sr_q, rx_q;
  logic [LW:0]   edge_q;
  logic [LW-1:0] len_q;
  logic          pha_q, last_q, sclk_q;
  logic          lead, smp, shf, final_edge;

  assign lead       = ~edge_q[0];
  assign smp        = lead ^ pha_q;
  assign shf        = ~smp && (edge_q != '0);
  assign final_edge = (edge_q == {len_q, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      rx_q    <= '0;
      edge_q  <= '0;
      len_q   <= '0;
      pha_q   <= 1'b0;
      last_q  <= 1'b0;
      sclk_q  <= 1'b0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        sr_q    <= tx_word << (TOP_IDX - len);
        rx_q    <= '0;
        edge_q  <= '0;
        len_q   <= len;
        pha_q   <= pha;
        last_q  <= 1'b0;
        sclk_q  <= 1'b0;
        running <= 1'b1;
      end else if (running && last_q) begin
        running <= 1'b0;
        last_q  <= 1'b0;
        done    <= 1'b1;
      end else if (running && tick) begin
        sclk_q <= ~sclk_q;
        if (smp) rx_q <= {rx_q[DW-2:0], miso};
        if (shf) sr_q <= {sr_q[DW-2:0], 1'b0};
        if (final_edge) last_q <= 1'b1;
        else            edge_q <= edge_q + 1'b1;
      end
    end
  end

  assign sclk_raw = sclk_q;
  assign mosi     = running && sr_q[DW-1];
  assign rx_word  = rx_q;
endmodule

// File: rtl/spi_reg_master.sv
`timescale 1ns/1ps
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs_n
);
  localparam int LW = $clog2(DW);

  ctrl_t         ctrl_q;
  logic          busy_q, done_flag, unr_q, ovf_q;
  logic          tx_full, rx_full;
  logic [DW-1:0] tx_q, rx_q;
  logic          wr_acc, rd_acc, wr_ctrl, wr_stat, wr_tx, rd_rx, go;
  logic          tick, eng_run, eng_done, sclk_raw;
  logic [DW-1:0] eng_rx;
  logic [DW-1:0] ctrl_rd, stat_rd;

  assign bus_ready = 1'b1;
  assign wr_acc  = bus_valid && bus_write;
  assign rd_acc  = bus_valid && !bus_write;
  assign wr_ctrl = wr_acc && (bus_addr == OFS_CTRL);
  assign wr_stat = wr_acc && (bus_addr == OFS_STAT);
  assign wr_tx   = wr_acc && (bus_addr == OFS_TXW);
  assign rd_rx   = rd_acc && (bus_addr == OFS_RXW);
  assign go      = wr_ctrl && !busy_q && bus_wdata[C_START];

  // control register: frozen while a transfer runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl && !busy_q) begin
      ctrl_q.pol    <= bus_wdata[C_POL_HI:C_POL_LO];
      ctrl_q.half   <= bus_wdata[C_HALF_HI:C_HALF_LO];
      ctrl_q.pha    <= bus_wdata[C_PHA_HI:C_PHA_LO];
      ctrl_q.tx_en  <= bus_wdata[C_TXEN];
      ctrl_q.rx_en  <= bus_wdata[C_RXEN];
      ctrl_q.cs_val <= bus_wdata[C_CSVAL];
      ctrl_q.cs_sw  <= bus_wdata[C_CSSW];
      ctrl_q.len    <= bus_wdata[LW-1:0];
    end
  end

  // activity and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_flag <= 1'b0;
      unr_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (go)            busy_q <= 1'b1;
      else if (eng_done) busy_q <= 1'b0;
      if (wr_stat && bus_wdata[S_DONE]) done_flag <= 1'b0;
      if (wr_stat && bus_wdata[S_UNR])  unr_q     <= 1'b0;
      if (wr_stat && bus_wdata[S_OVF])  ovf_q     <= 1'b0;
      if (eng_done)           done_flag <= 1'b1;
      if (rd_rx && !rx_full)  unr_q     <= 1'b1;
      if (wr_tx && tx_full)   ovf_q     <= 1'b1;
    end
  end

  // transmit holding word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      tx_full <= 1'b0;
    end else begin
      if (go || (wr_stat && bus_wdata[S_TXFL])) tx_full <= 1'b0;
      if (wr_tx && !tx_full) begin
        tx_q    <= bus_wdata;
        tx_full <= 1'b1;
      end
    end
  end

  // receive holding word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      rx_full <= 1'b0;
    end else begin
      if (rd_rx || (wr_stat && bus_wdata[S_RXFL])) rx_full <= 1'b0;
      if (eng_done && ctrl_q.rx_en) begin
        rx_q    <= eng_rx;
        rx_full <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[C_START]            = busy_q;
    ctrl_rd[C_POL_HI:C_POL_LO]   = ctrl_q.pol;
    ctrl_rd[C_HALF_HI:C_HALF_LO] = ctrl_q.half;
    ctrl_rd[C_PHA_HI:C_PHA_LO]   = ctrl_q.pha;
    ctrl_rd[C_TXEN]             = ctrl_q.tx_en;
    ctrl_rd[C_RXEN]             = ctrl_q.rx_en;
    ctrl_rd[C_CSVAL]            = ctrl_q.cs_val;
    ctrl_rd[C_CSSW]             = ctrl_q.cs_sw;
    ctrl_rd[LW-1:0]             = ctrl_q.len;
    stat_rd = '0;
    stat_rd[S_BUSY] = busy_q;
    stat_rd[S_DONE] = done_flag;
    stat_rd[S_UNR]  = unr_q;
    stat_rd[S_OVF]  = ovf_q;
    stat_rd[S_RXE]  = !rx_full;
    stat_rd[S_RXF]  = rx_full;
    stat_rd[S_TXE]  = !tx_full;
    stat_rd[S_TXF]  = tx_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) begin
        unique case (bus_addr)
          OFS_CTRL: rd_data <= ctrl_rd;
          OFS_STAT: rd_data <= stat_rd;
          OFS_RXW:  rd_data <= rx_full ? rx_q : '0;
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  spi_clk_div #(.HW(HALF_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_run),
    .half (ctrl_q.half),
    .tick (tick)
  );

  spi_shift_engine #(.DW(DW), .LW(LW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (go),
    .len     (bus_wdata[LW-1:0]),
    .pha     (|bus_wdata[C_PHA_HI:C_PHA_LO]),
    .tx_word (ctrl_q.tx_en || bus_wdata[C_TXEN] ? (bus_wdata[C_TXEN] ? tx_q : '0) : '0),
    .miso    (spi_miso),
    .tick    (tick),
    .running (eng_run),
    .sclk_raw(sclk_raw),
    .mosi    (spi_mosi),
    .done    (eng_done),
    .rx_word (eng_rx)
  );

  assign spi_sclk = sclk_raw ^ (|ctrl_q.pol);
  assign spi_cs_n = ctrl_q.cs_sw ? !ctrl_q.cs_val : !busy_q;
endmodule

// File: rtl/spi_reg_master_chk.sv
`timescale 1ns/1ps
module spi_reg_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        rd_valid,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        busy,
  input logic        done_flag,
  input logic        ovf,
  input logic        tx_full,
  input logic        cs_sw,
  input logic [1:0]  pol
);
  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  // R9
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_sw) |-> !spi_cs_n);

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == (|pol)));

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 6'h10 && tx_full) |=> ovf);

  // R7
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !(bus_valid && bus_write && bus_addr == 6'h04 && bus_wdata[30])) |=> done_flag);
endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rd_valid (rd_valid),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n),
  .busy     (busy_q),
  .done_flag(done_flag),
  .ovf      (ovf_q),
  .tx_full  (tx_full),
  .cs_sw    (ctrl_q.cs_sw),
  .pol      (ctrl_q.pol)
);

// File: tb/sim_spi_reg_master.sv
`timescale 1ns/1ps
module sim_spi_reg_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rd_valid, spi_sclk, spi_mosi, spi_miso, spi_cs_n;
  logic [31:0] rd_data;

  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;
  assign spi_miso = ~spi_mosi;

  spi_reg_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // wire monitor: rebuilds the bits the target would see
  logic        mon_pol = 1'b0, mon_pha = 1'b0;
  logic [31:0] mon_cap = '0;
  int          mon_smp = 0, mon_edges = 0;
  longint      mon_last = 0, mon_gap = 0;

  always @(spi_sclk) begin
    #1;
    if (!spi_cs_n) begin
      if (mon_edges > 0) mon_gap = $time - mon_last;
      mon_last = $time;
      mon_edges++;
      if ((spi_sclk != mon_pol) == !mon_pha) begin
        mon_cap = {mon_cap[30:0], spi_mosi};
        mon_smp++;
      end
    end
  end

  // {pol, pha, len[4:0], half[3:0], tx[31:0]}
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'd7,  4'd0, 32'h0000_00A5},
    {1'b0, 1'b1, 5'd15, 4'd1, 32'h0000_1234},
    {1'b1, 1'b0, 5'd31, 4'd2, 32'hDEAD_BEEF},
    {1'b1, 1'b1, 5'd0,  4'd0, 32'h0000_0001},
    {1'b0, 1'b0, 5'd31, 4'd0, 32'h8000_0001},
    {1'b1, 1'b1, 5'd11, 4'd3, 32'h0000_0ABC},
    {1'b0, 1'b1, 5'd4,  4'd0, 32'hFFFF_FF15},
    {1'b1, 1'b0, 5'd23, 4'd1, 32'h00C3_5A3C}
  };

  function automatic logic [31:0] lowmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic wait_done(output logic [31:0] st);
    logic v;
    st = '0;
    for (int k = 0; k < 3000; k++) begin
      bus_rd(6'h04, st, v);
      if (st[30]) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] d, st, cfg;
    logic v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
    check("R1 sclk", {31'b0, spi_sclk}, 32'h0);
    rst_n = 1'b1;
    bus_rd(6'h00, d, v); check("R1 ctrl", d, 32'h0);
    check("R11 rd_valid", {31'b0, v}, 32'h1);
    bus_rd(6'h04, d, v); check("R1 status", d, 32'h0280_0000);
    check("R11 bus_ready", {31'b0, bus_ready}, 32'h1);

    // vector table: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      logic [42:0] e;
      int n;
      e = VEC[i];
      n = int'(e[40:36]) + 1;
      mon_pol = e[42]; mon_pha = e[41];
      cfg = (e[42] ? 32'h0400_0000 : 32'h0) | ({28'b0, e[35:32]} << 22) |
            (e[41] ? 32'h0004_0000 : 32'h0) | 32'h0000_C000 | {27'b0, e[40:36]};
      bus_wr(6'h00, cfg);
      bus_wr(6'h10, e[31:0]);
      mon_cap = '0; mon_smp = 0; mon_edges = 0; mon_gap = 0;
      bus_wr(6'h00, cfg | 32'h4000_0000);
      bus_rd(6'h00, d, v); check("R2 start bit reads busy", d[30] ? 32'h1 : 32'h0, 32'h1);
      wait_done(st);
      check("R6 status after transfer", st, 32'h4180_0000);
      check("R2 bit count", mon_smp, n);
      check("R2 mosi word", mon_cap & lowmask(n), e[31:0] & lowmask(n));
      check("R4 idle level", {31'b0, spi_sclk}, {31'b0, e[42]});
      if (n > 1) check("R5 half period ns", 32'(mon_gap), (int'(e[35:32]) + 1) * 10);
      bus_rd(6'h20, d, v); check("R3 rx word", d, ~e[31:0] & lowmask(n));
      bus_wr(6'h04, 32'h4000_0000);
      bus_rd(6'h04, d, v); check("R7 done cleared", d, 32'h0280_0000);
    end

    // R3 receive disabled, transmit disabled sends zeros
    mon_pol = 1'b0; mon_pha = 1'b0;
    bus_wr(6'h10, 32'hFF);
    mon_cap = '0; mon_smp = 0;
    bus_wr(6'h00, 32'h4000_0007);
    wait_done(st);
    check("R3 rx disabled status", st, 32'h4280_0000);
    check("R3 tx disabled mosi", mon_cap, 32'h0);
    bus_wr(6'h04, 32'h4000_0000);

    // R8 underrun and overflow, R7 write-0 keeps
    bus_rd(6'h20, d, v); check("R8 empty read data", d, 32'h0);
    bus_wr(6'h10, 32'h1);
    bus_wr(6'h10, 32'h2);
    bus_rd(6'h04, d, v); check("R8 flags", d, 32'h0E40_0000);
    bus_wr(6'h04, 32'h0000_0000);
    bus_rd(6'h04, d, v); check("R7 write 0 keeps", d, 32'h0E40_0000);
    bus_wr(6'h04, 32'h0C00_0000);
    bus_rd(6'h04, d, v); check("R7 write 1 clears", d, 32'h0240_0000);
    // R10 flush transmit
    bus_wr(6'h04, 32'h1000_0000);
    bus_rd(6'h04, d, v); check("R10 tx flush", d, 32'h0280_0000);

    // R10 flush receive after a stored word; R8 overflow dropped data
    bus_wr(6'h10, 32'h3C);
    bus_wr(6'h10, 32'hAA);
    mon_cap = '0; mon_smp = 0;
    bus_wr(6'h00, 32'h4000_C007);
    wait_done(st);
    check("R8 dropped write", mon_cap, 32'h3C);
    bus_wr(6'h04, 32'h6400_0000);
    bus_rd(6'h04, d, v); check("R10 rx flush", d, 32'h0280_0000);

    // R9 software chip select
    bus_wr(6'h00, 32'h0000_3000);
    check("R9 soft cs low", {31'b0, spi_cs_n}, 32'h0);
    bus_wr(6'h00, 32'h0000_1000);
    check("R9 soft cs high", {31'b0, spi_cs_n}, 32'h1);
    bus_wr(6'h00, 32'h0000_0000);
    check("R9 hw cs idle", {31'b0, spi_cs_n}, 32'h1);

    // R11 unmapped offsets
    bus_wr(6'h14, 32'hFFFF_FFFF);
    bus_rd(6'h14, d, v); check("R11 offset 0x14", d, 32'h0);
    bus_rd(6'h08, d, v); check("R11 offset 0x08", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule